// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block lets a device that has raised a threshold alert answer the SMBus alert-response query. It watches sampled SCL and SDA lines. When a controller reads the alert-response address (seven-bit 0001100 with the read bit set, so the byte 0x19 on the wire) while the device's alert is pending and interrupt mode is enabled, the block acknowledges the byte. It then shifts out its own seven-bit address, most significant bit first, followed by a cause bit.

Several devices can answer the same query. The block arbitrates bit by bit on the open-drain line. It clears its alert, through a one-cycle `alert_clear` pulse to an external latch, only when it has sent the whole byte without losing arbitration. If it loses, it leaves the bus alone until the next START or STOP, and its alert stays pending.

The controller is a single state machine with these states:
- `S_IDLE`: after reset or STOP.
- `S_ADDR`: collects the eight command bits.
- `S_ACK_SETUP`: waits for SCL to fall.
- `S_ACK_DRIVE`: pulls SDA low for the acknowledge.
- `S_RESP`: shifts out the response byte.
- `S_HOST_ACK`: waits for the controller's acknowledge clock.
- `S_WAIT_STOP`: stays off the bus until the next START or STOP.

The transitions are:
- A START in any state enters `S_ADDR`.
- A STOP in any state enters `S_IDLE`.
- `S_ADDR` goes to `S_ACK_SETUP` on a match, or to `S_WAIT_STOP` otherwise.
- `S_ACK_SETUP` goes to `S_ACK_DRIVE` on the next SCL fall.
- `S_ACK_DRIVE` goes to `S_RESP` on the next SCL fall.
- `S_RESP` goes to `S_WAIT_STOP` when arbitration is lost, or to `S_HOST_ACK` after the eighth bit.
- `S_HOST_ACK` goes to `S_WAIT_STOP` on the next SCL rise, pulsing the clear.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset, `sda_pull` is 0 and `alert_clear` is 0.
- R2: When the byte 0x19 is received while `alert_pending`=1 and `irq_mode_en`=1, the block pulls SDA low during the ninth SCL clock (acknowledge).
- R3: When `alert_pending`=0, the 0x19 byte is not acknowledged and SDA stays released for the whole transfer (the controller reads 0xFF).
- R4: When `irq_mode_en`=0, the 0x19 byte is not acknowledged and SDA stays released.
- R5: Any other first byte, including 0x18 (the alert address with the write bit) and the device's own address, is ignored: no acknowledge and no clear.
- R6: After acknowledging, the block transmits `dev_addr` MSB first as response bits 7 down to 1.
- R7: Response bit 0 equals `cause_high` XNOR `pol_invert`. With `pol_invert`=0 it is 0 for a high-threshold cause (`cause_high`=1) and 1 for a low-threshold cause; `pol_invert`=1 inverts it.
- R8: If the block releases SDA to send a 1 but samples SDA low at the following SCL rise, it loses arbitration, drives nothing more until the next START or STOP, and does not clear the alert.
- R9: After a complete response byte, the block emits `alert_clear` for exactly one clock on the rising edge of the controller's ninth clock, whether that bit is ACK or NACK.
- R10: A START or STOP at any point aborts the transfer with no clear. A repeated START restarts command recognition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired-AND of all drivers) |
| irq_mode_en | input | 1 | Interrupt mode enabled; the responder is inactive when 0 |
| alert_pending | input | 1 | The device has an unserviced alert |
| cause_high | input | 1 | 1 = high threshold reached, 0 = below low threshold |
| pol_invert | input | 1 | Inverts the cause bit |
| dev_addr | input | 7 | The device's own bus address |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| alert_clear | output | 1 | One-cycle pulse that clears the external alert latch |

## Verification
The bench builds the block with `SYNC_STAGES`=3, the default alert address and a device address of 0x4A. With ten system clocks per bus phase, this shows that the deeper synchronizer still decodes START, STOP and every bit inside one phase. The address 0x4A against competing responders at 0x48 and 0x4B puts both an arbitration loss and an arbitration win within reach. Both happen in the low address bits, after several bits have already matched. In the lost case, the last bit that would have been driven is a 0 where the winner sends a 1, so any driving after the loss shows on the line.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_ADDR      = 3'd1,
        S_ACK_SETUP = 3'd2,
        S_ACK_DRIVE = 3'd3,
        S_RESP      = 3'd4,
        S_HOST_ACK  = 3'd5,
        S_WAIT_STOP = 3'd6
    } resp_state_t;

endpackage

// File: rtl/smb_bus_events.sv
module smb_bus_events #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_q, sda_q;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[SYNC_STAGES-1:0], scl_in} >> 0;
                    sda_chain <= {sda_chain[SYNC_STAGES-1:0], sda_in} >> 0;
                end
            end
            assign scl_s = scl_chain[SYNC_STAGES-1];
            assign sda_s = sda_chain[SYNC_STAGES-1];
        end else begin : g_direct
            assign scl_s = scl_in;
            assign sda_s = sda_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edges of the clock line; data edges while the clock is high are frame markers.
    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign bus_start =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign bus_stop  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/smb_resp_byte.sv
module smb_resp_byte #(
    parameter int ADDR_W = 7,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              cause_high,
    input  logic              pol_invert,
    output logic [BYTE_W-1:0] resp_byte
);
    // Low for a high-threshold cause when polarity is normal; the polarity bit flips it.
    logic cause_bit;
    assign cause_bit = ~cause_high ^ pol_invert;
    assign resp_byte = {dev_addr, cause_bit};
endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder #(
    parameter int              ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] ARA_ADDR  = 7'b0001100,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              irq_mode_en,
    input  logic              alert_pending,
    input  logic              cause_high,
    input  logic              pol_invert,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              sda_pull,
    output logic              alert_clear
);
    import smb_alert_pkg::*;

    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [BYTE_W-1:0] ARA_READ = {ARA_ADDR, 1'b1};

    logic scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;

    smb_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (ev_start),
        .bus_stop  (ev_stop)
    );

    logic [BYTE_W-1:0] resp_byte;

    smb_resp_byte #(.ADDR_W(ADDR_W)) u_resp (
        .dev_addr   (dev_addr),
        .cause_high (cause_high),
        .pol_invert (pol_invert),
        .resp_byte  (resp_byte)
    );

    resp_state_t       state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [BYTE_W-1:0] shreg, shreg_n;
    logic              lost, lost_n;
    logic              clr_n, pull_n;
    logic [BYTE_W-1:0] rx_byte;
    logic              hit, tx_bit;

    assign rx_byte = {shreg[BYTE_W-2:0], sda_s};
    assign hit     = (rx_byte == ARA_READ) && alert_pending && irq_mode_en;
    assign tx_bit  = resp_byte[LAST_BIT - cnt];

    // Next-state logic
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        shreg_n = shreg;
        lost_n  = lost;
        clr_n   = 1'b0;
        if (ev_stop) begin
            state_n = S_IDLE;
            cnt_n   = '0;
            lost_n  = 1'b0;
        end else if (ev_start) begin
            state_n = S_ADDR;
            cnt_n   = '0;
            shreg_n = '0;
            lost_n  = 1'b0;
        end else begin
            unique case (state)
                S_IDLE, S_WAIT_STOP: begin
                end
                S_ADDR: begin
                    if (scl_rise) begin
                        shreg_n = rx_byte;
                        if (cnt == LAST_BIT) begin
                            cnt_n   = '0;
                            state_n = hit ? S_ACK_SETUP : S_WAIT_STOP;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                S_ACK_SETUP: begin
                    if (scl_fall) state_n = S_ACK_DRIVE;
                end
                S_ACK_DRIVE: begin
                    if (scl_fall) begin
                        state_n = S_RESP;
                        cnt_n   = '0;
                    end
                end
                S_RESP: begin
                    if (scl_rise && tx_bit && !sda_s) begin
                        lost_n  = 1'b1;
                        state_n = S_WAIT_STOP;
                    end else if (scl_fall) begin
                        if (cnt == LAST_BIT) state_n = S_HOST_ACK;
                        else                 cnt_n   = cnt + 1'b1;
                    end
                end
                S_HOST_ACK: begin
                    if (scl_rise) begin
                        clr_n   = alert_pending & irq_mode_en;
                        state_n = S_WAIT_STOP;
                    end
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    assign pull_n = (state_n == S_ACK_DRIVE) ||
                    ((state_n == S_RESP) && !resp_byte[LAST_BIT - cnt_n]);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            shreg <= '0;
            lost  <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            shreg <= shreg_n;
            lost  <= lost_n;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_pull    <= 1'b0;
            alert_clear <= 1'b0;
        end else begin
            sda_pull    <= pull_n;
            alert_clear <= clr_n;
        end
    end

    assert_clear_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alert_clear |=> !alert_clear);

    assert_clear_on_clock_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alert_clear |-> $past(scl_rise));

    assert_released_after_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> !sda_pull);

    assert_loss_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> $past(scl_rise && !sda_s && state == S_RESP));

    assert_no_clear_after_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> !alert_clear);

    assert_sda_steady_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull));
endmodule

// File: tb/test_smb_alert_responder.sv
module test_smb_alert_responder;
    localparam int HP = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1, rival_pull = 1'b0;
    logic irq_mode_en = 1'b1, alert_pending = 1'b1, cause_high = 1'b1, pol_invert = 1'b0;
    logic [6:0] dev_addr = 7'h4A;
    logic sda_pull, alert_clear;
    wire  sda_line = m_sda & ~sda_pull & ~rival_pull;

    smb_alert_responder #(.ADDR_W(7), .SYNC_STAGES(3)) i_smb_alert_responder (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .irq_mode_en(irq_mode_en), .alert_pending(alert_pending),
        .cause_high(cause_high), .pol_invert(pol_invert), .dev_addr(dev_addr),
        .sda_pull(sda_pull), .alert_clear(alert_clear)
    );

    int n_cmp = 0, n_bad = 0;
    int clr_cnt = 0, multi_cnt = 0;
    logic clr_prev = 1'b0;
    int    exp_q[$];
    string tag_q[$];
    int    obs_q[$];

    always @(negedge clk) begin
        if (alert_clear) clr_cnt++;
        if (alert_clear && clr_prev) multi_cnt++;
        clr_prev = alert_clear;
    end

    function automatic void expect_item(int v, string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endfunction

    function automatic void observe(int v);
        obs_q.push_back(v);
    endfunction

    // Monitor: pairs observations with expectations in order
    always @(negedge clk) begin
        while (exp_q.size() > 0 && obs_q.size() > 0) begin
            int e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = obs_q.pop_front();
            n_cmp++;
            if (a != e) begin
                n_bad++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
            end
        end
    end

    task automatic half();
        repeat (HP) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; half();
        m_scl = 1'b1; half();
        m_sda = 1'b0; half();
        m_scl = 1'b0; half();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; half();
        m_scl = 1'b1; half();
        m_sda = 1'b1; half();
    endtask

    task automatic clk_bit(input logic mb, input logic rb, output logic seen);
        m_sda = mb;
        rival_pull = ~rb;
        half();
        m_scl = 1'b1;
        repeat (HP/2) @(negedge clk);
        seen = sda_line;
        repeat (HP - HP/2) @(negedge clk);
        m_scl = 1'b0;
        half();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b1, s);
        clk_bit(1'b1, 1'b1, s);
        acked = ~s;
    endtask

    task automatic read_byte(input logic rival_en, input logic [7:0] rival,
                             input logic m_ack, output logic [7:0] got);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, rival_en ? rival[i] : 1'b1, s);
            got[i] = s;
        end
        clk_bit(~m_ack, 1'b1, s);
        rival_pull = 1'b0;
    endtask

    // Driver: one alert-response read, pushing the expected items
    task automatic run_ara(input logic exp_ack, input int exp_byte, input logic m_ack,
                           input logic rival_en, input logic [7:0] rival,
                           input int exp_clr, input string tag);
        logic acked;
        logic [7:0] got;
        int c0;
        c0 = clr_cnt;
        bus_start();
        send_byte(8'h19, acked);
        expect_item(exp_ack, {tag, " ack"});
        observe(acked);
        read_byte(rival_en, rival, m_ack, got);
        expect_item(exp_byte, {tag, " byte"});
        observe(got);
        bus_stop();
        half();
        expect_item(exp_clr, {tag, " clear count"});
        observe(clr_cnt - c0);
        expect_item(0, {tag, " bus released"});
        observe(sda_pull);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_item(0, "R1 sda_pull after reset");  observe(sda_pull);
        expect_item(0, "R1 alert_clear after reset"); observe(alert_clear);
        half();

        // R2 R6 R7 R9: high cause, normal polarity, controller NACKs
        cause_high = 1'b1; pol_invert = 1'b0;
        run_ara(1, 8'h94, 1'b0, 1'b0, 8'hFF, 1, "R2/R6/R7/R9 high pol0 nack");
        // R7 R9: low cause, normal polarity, controller ACKs
        cause_high = 1'b0;
        run_ara(1, 8'h95, 1'b1, 1'b0, 8'hFF, 1, "R7/R9 low pol0 ack");
        // R7: inverted polarity, both causes
        cause_high = 1'b1; pol_invert = 1'b1;
        run_ara(1, 8'h95, 1'b0, 1'b0, 8'hFF, 1, "R7 high pol1");
        cause_high = 1'b0;
        run_ara(1, 8'h94, 1'b0, 1'b0, 8'hFF, 1, "R7 low pol1");
        pol_invert = 1'b0; cause_high = 1'b1;

        // R3: no alert pending
        alert_pending = 1'b0;
        run_ara(0, 8'hFF, 1'b0, 1'b0, 8'hFF, 0, "R3 not pending");
        alert_pending = 1'b1;
        // R4: interrupt mode disabled
        irq_mode_en = 1'b0;
        run_ara(0, 8'hFF, 1'b0, 1'b0, 8'hFF, 0, "R4 mode off");
        irq_mode_en = 1'b1;

        // R5: write to the alert address, then a read of the own address
        begin
            logic acked;
            int c0;
            c0 = clr_cnt;
            bus_start();
            send_byte(8'h18, acked);
            expect_item(0, "R5 alert addr write ack"); observe(acked);
            bus_stop();
            bus_start();
            send_byte(8'h95, acked);
            expect_item(0, "R5 own addr read ack"); observe(acked);
            bus_stop();
            half();
            expect_item(0, "R5 clear count"); observe(clr_cnt - c0);
        end

        // R8: lose to a lower address (0x48, cause bit 1), then win against 0x4B
        run_ara(1, 8'h91, 1'b0, 1'b1, 8'h91, 0, "R8 arbitration lost");
        run_ara(1, 8'h94, 1'b0, 1'b1, 8'h97, 1, "R8 arbitration won");

        // R10: repeated start in mid-command restarts recognition
        begin
            logic s, acked;
            logic [7:0] got;
            int c0;
            c0 = clr_cnt;
            bus_start();
            clk_bit(1'b0, 1'b1, s); clk_bit(1'b0, 1'b1, s);
            clk_bit(1'b0, 1'b1, s); clk_bit(1'b1, 1'b1, s);
            bus_start();
            send_byte(8'h19, acked);
            expect_item(1, "R10 ack after repeated start"); observe(acked);
            read_byte(1'b0, 8'hFF, 1'b0, got);
            expect_item(8'h94, "R10 byte after repeated start"); observe(got);
            bus_stop();
            half();
            expect_item(1, "R10 clear after repeated start"); observe(clr_cnt - c0);
        end

        // R10: stop right after the acknowledge aborts with no clear
        begin
            logic acked;
            int c0;
            c0 = clr_cnt;
            bus_start();
            send_byte(8'h19, acked);
            expect_item(1, "R10 ack before abort"); observe(acked);
            bus_stop();
            half();
            expect_item(0, "R10 no clear on abort"); observe(clr_cnt - c0);
            expect_item(0, "R10 released on abort"); observe(sda_pull);
        end

        expect_item(0, "R9 multi-cycle clear pulses"); observe(multi_cnt);
        repeat (5) @(negedge clk);
        if (exp_q.size() != 0 || obs_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %0d left expected %0d", obs_q.size(), exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule